// File: doc/BRIEF.md
# Register-Mapped Packet FIFO with Length Framing

This block is a full-duplex packet buffer placed between a 32-bit register bus and a word-wide streaming MAC interface. Software builds an outgoing packet by writing data words into the transmit data port and then writing the packet's byte length. That length write commits the packet, and a stream engine then sends it out word by word. Incoming packets arrive on the receive stream and are stored. The byte length of a received packet becomes readable only once the final word is held. Software reads the length first and then drains that many words from the receive data port.

Each direction holds 2 KB. The ring keeps one slot spare, so 511 words are usable. The register window also holds an interrupt status register (write one to clear), an interrupt enable register, a transmit vacancy count, a receive occupancy count, and three reset registers that act only on a magic key value. The interrupt output is high while any enabled status bit is set.

The transmit engine has two states, `TX_IDLE` and `TX_SEND`. It moves from `TX_IDLE` to `TX_SEND` when a committed length is queued. It returns to `TX_IDLE` when the last word of the packet is accepted, or when the transmit side is cleared. The receive engine has three states, `RX_IDLE`, `RX_RECV` and `RX_DROP`:
- A beat that is not last and has room moves it into `RX_RECV`.
- A last beat returns it to `RX_IDLE`.
- A beat that finds no room discards the partial packet and moves to `RX_DROP`. If that beat is the last one, the engine goes to `RX_IDLE` instead.
- From `RX_DROP` it returns to `RX_IDLE` on the last beat.

Top module: `pkt_fifo_mm`

Register offsets (word index on `i_bus_addr`):

| Index | Register |
|-------|----------|
| 0 | status |
| 1 | enable |
| 2 | TX clear |
| 3 | TX vacancy |
| 4 | TX data |
| 5 | TX length |
| 6 | RX clear |
| 7 | RX occupancy |
| 8 | RX data |
| 9 | RX length |
| 10 | stream clear |

Status and enable bits:

| Bit | Flag |
|-----|------|
| 23 | RX clear done |
| 24 | TX clear done |
| 25 | TX size error |
| 26 | RX packet complete |
| 27 | TX packet complete |
| 28 | TX data overrun |
| 29 | RX packet dropped |
| 30 | RX read past packet |
| 31 | RX read with nothing available |

## Requirements
- R1: After reset, all of the following hold: status is 0, enable is 0, TX vacancy (index 3) reads 511, RX occupancy (index 7) reads 0, `o_tx_valid` is 0 and `o_irq` is 0. A read access returns its data with `o_bus_rvalid` high one cycle later.
- R2: TX vacancy equals 511 minus the words held on the transmit side. Each accepted data write at index 4 lowers it by one, and each streamed word raises it by one.
- R3: The packet is committed by a write at index 5 when all of these hold: the length in bits 10:0 is between 16 and 2040, ceil(length/4) equals the number of words written since the last commit, and the length queue has room. The words are then streamed in write order, with `o_tx_last` on the final word and `o_tx_len` showing the length. The stream holds its data while `i_tx_ready` is low. Acceptance of the last word sets status bit 27.
- R4: A length write that fails R3 sets status bit 25 and discards the uncommitted words, so vacancy returns to its previous committed value. Nothing is streamed for that packet.
- R5: A data write at index 4 while vacancy is 0 is ignored (vacancy stays 0) and sets status bit 28.
- R6: A write of exactly 0x000000A5 clears a side:
  - index 2 clears the transmit side and sets bit 24;
  - index 6 clears the receive side and sets bit 23;
  - index 10 clears both sides and sets bits 24 and 23.
  Any other value written there has no effect.
- R7: When the last beat of a received packet is stored, RX occupancy grows by the packet's word count and status bit 26 is set. The length at index 9 equals 4 times the earlier words plus the tail bytes of the last beat, where `i_rx_tail` 0 means 4. The words then read at index 8 appear in arrival order.
- R8: A read at index 9 returns 0 and sets bit 31 in either of two cases: no complete packet is queued, or the previous packet's words are not yet all drained.
- R9: A read at index 8 with no opened packet returns 0. It sets bit 30 if occupancy is nonzero and bit 31 if occupancy is zero, and it does not change occupancy.
- R10: An incoming beat that finds the receive ring full drops the whole packet. Occupancy is unchanged and bit 29 is set.
- R11: Writing index 0 clears exactly the status bits written as one. A set event in the same cycle wins over the clear.
- R12: `o_irq` is high exactly when some status bit and its enable bit (index 1, same layout) are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_rst_n | input | 1 | Asynchronous active-low reset |
| i_bus_sel | input | 1 | Register access strobe |
| i_bus_wr | input | 1 | 1 = write, 0 = read |
| i_bus_addr | input | 4 | Register word index |
| i_bus_wdata | input | 32 | Write data |
| o_bus_rdata | output | 32 | Read data, registered |
| o_bus_rvalid | output | 1 | Read data valid, one cycle after access |
| o_tx_valid | output | 1 | Transmit word valid |
| o_tx_data | output | 32 | Transmit word |
| o_tx_last | output | 1 | Final word of packet |
| o_tx_len | output | 11 | Byte length of packet being sent |
| i_tx_ready | input | 1 | MAC accepts transmit word |
| i_rx_valid | input | 1 | Receive word valid |
| i_rx_data | input | 32 | Receive word |
| i_rx_last | input | 1 | Final word of packet |
| i_rx_tail | input | 2 | Valid bytes in final word, 0 means 4 |
| o_irq | output | 1 | Interrupt request |

## Verification
Register reads come back in the cycle after the access edge. Writes and stream beats update status, vacancy and occupancy at that same edge, so the bench samples everything at the falling edge that follows. A committed transmit length gives `o_tx_valid` two edges after the length write: one edge to queue the length and one for `TX_IDLE` to become `TX_SEND`. The bench waits on `o_tx_valid` and checks each word in the half cycle before the edge that takes it. Status after the last transmit word or the last receive beat is read with a register access that starts at the next falling edge, after the setting edge has passed. `o_irq` is combinational from status and enable, so it is checked right after that edge.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [3:0] {
        RG_STATUS   = 4'd0,
        RG_ENABLE   = 4'd1,
        RG_TX_CLR   = 4'd2,
        RG_TX_VAC   = 4'd3,
        RG_TX_DATA  = 4'd4,
        RG_TX_LEN   = 4'd5,
        RG_RX_CLR   = 4'd6,
        RG_RX_OCC   = 4'd7,
        RG_RX_DATA  = 4'd8,
        RG_RX_LEN   = 4'd9,
        RG_LINK_CLR = 4'd10
    } reg_ofs_e;

    localparam logic [31:0] CLR_KEY = 32'h0000_00A5;

    // status vector index i maps to register bit ST_LSB + i
    localparam int ST_LSB    = 23;
    localparam int ST_W      = 9;
    localparam int SB_RX_CLR = 0;
    localparam int SB_TX_CLR = 1;
    localparam int SB_TX_SZ  = 2;
    localparam int SB_RX_DN  = 3;
    localparam int SB_TX_DN  = 4;
    localparam int SB_TX_OVF = 5;
    localparam int SB_RX_DRP = 6;
    localparam int SB_RX_OVR = 7;
    localparam int SB_RX_UND = 8;

    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_RECV, RX_DROP} rx_state_e;

endpackage

// File: rtl/pf_word_ring.sv
module pf_word_ring #(
    parameter int DEPTH = 512,
    parameter int W     = 32
) (
    input  logic                       i_clk,
    input  logic                       i_rst_n,
    input  logic                       i_clr,
    input  logic                       i_push,
    input  logic [W-1:0]               i_push_data,
    input  logic                       i_commit,
    input  logic                       i_rewind,
    input  logic                       i_pop,
    output logic [W-1:0]               o_head,
    output logic [$clog2(DEPTH)-1:0]   o_free,
    output logic [$clog2(DEPTH)-1:0]   o_staged,
    output logic [$clog2(DEPTH)-1:0]   o_ready
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, cm_q, rd_q;

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            wr_q <= '0;
            cm_q <= '0;
            rd_q <= '0;
        end else if (i_clr) begin
            wr_q <= '0;
            cm_q <= '0;
            rd_q <= '0;
        end else begin
            if (i_rewind) begin
                wr_q <= cm_q;
            end else begin
                if (i_push)   wr_q <= wr_q + 1'b1;
                if (i_commit) cm_q <= wr_q + AW'(i_push);
            end
            if (i_pop) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge i_clk) begin
        if (i_push && !i_rewind && !i_clr) mem[wr_q] <= i_push_data;
    end

    assign o_head   = mem[rd_q];
    assign o_free   = AW'(DEPTH - 1) - (wr_q - rd_q);
    assign o_staged = wr_q - cm_q;
    assign o_ready  = cm_q - rd_q;

endmodule

// File: rtl/pf_len_fifo.sv
module pf_len_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         i_clk,
    input  logic         i_rst_n,
    input  logic         i_clr,
    input  logic         i_push,
    input  logic [W-1:0] i_din,
    input  logic         i_pop,
    output logic [W-1:0] o_head,
    output logic         o_empty,
    output logic         o_full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [PW:0]   cnt_q;

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (i_clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (i_push && !o_full) wp_q <= wp_q + 1'b1;
            if (i_pop && !o_empty) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PW+1)'(i_push && !o_full) - (PW+1)'(i_pop && !o_empty);
        end
    end

    always_ff @(posedge i_clk) begin
        if (i_push && !o_full && !i_clr) slot[wp_q] <= i_din;
    end

    assign o_head  = slot[rp_q];
    assign o_empty = (cnt_q == '0);
    assign o_full  = (cnt_q == (PW+1)'(DEPTH));

endmodule

// File: rtl/pf_tx_stream.sv
module pf_tx_stream
    import pf_pkg::*;
#(
    parameter int AW = 9,
    parameter int LW = 11
) (
    input  logic          i_clk,
    input  logic          i_rst_n,
    input  logic          i_clr,
    input  logic          i_len_empty,
    input  logic [LW-1:0] i_len_head,
    input  logic [31:0]   i_word,
    input  logic          i_ready,
    output logic          o_valid,
    output logic [31:0]   o_data,
    output logic          o_last,
    output logic [LW-1:0] o_len,
    output logic          o_pop_word,
    output logic          o_pop_len,
    output logic          o_done
);
    tx_state_e     state_q, state_d;
    logic [AW-1:0] left_q;
    logic [LW:0]   len_round;

    assign len_round = {1'b0, i_len_head} + (LW+1)'(3);

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            state_q <= TX_IDLE;
            left_q  <= '0;
        end else if (i_clr) begin
            state_q <= TX_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && !i_len_empty) left_q <= len_round[AW+1:2];
            else if (o_pop_word)                    left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        state_d    = state_q;
        o_valid    = 1'b0;
        o_last     = 1'b0;
        o_pop_word = 1'b0;
        o_pop_len  = 1'b0;
        o_done     = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (!i_len_empty) state_d = TX_SEND;
            end
            TX_SEND: begin
                o_valid = 1'b1;
                o_last  = (left_q == AW'(1));
                if (i_ready) begin
                    o_pop_word = 1'b1;
                    if (o_last) begin
                        o_pop_len = 1'b1;
                        o_done    = 1'b1;
                        state_d   = TX_IDLE;
                    end
                end
            end
        endcase
    end

    assign o_data = i_word;
    assign o_len  = i_len_head;

endmodule

// File: rtl/pf_rx_stream.sv
module pf_rx_stream
    import pf_pkg::*;
#(
    parameter int AW = 9,
    parameter int LW = 11
) (
    input  logic          i_clk,
    input  logic          i_rst_n,
    input  logic          i_clr,
    input  logic          i_valid,
    input  logic          i_last,
    input  logic [1:0]    i_tail,
    input  logic [AW-1:0] i_free,
    input  logic          i_len_full,
    output logic          o_push,
    output logic          o_commit,
    output logic          o_rewind,
    output logic          o_len_push,
    output logic [LW-1:0] o_len,
    output logic          o_drop,
    output logic          o_done
);
    rx_state_e     state_q, state_d;
    logic [AW-1:0] cnt_q;

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else if (i_clr) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RX_RECV) cnt_q <= cnt_q + AW'(o_push);
            else                    cnt_q <= '0;
        end
    end

    always_comb begin
        state_d    = state_q;
        o_push     = 1'b0;
        o_commit   = 1'b0;
        o_rewind   = 1'b0;
        o_len_push = 1'b0;
        o_drop     = 1'b0;
        o_done     = 1'b0;
        unique case (state_q)
            RX_IDLE, RX_RECV: begin
                if (i_valid) begin
                    if (i_free == '0) begin
                        o_rewind = 1'b1;
                        o_drop   = 1'b1;
                        state_d  = i_last ? RX_IDLE : RX_DROP;
                    end else if (i_last) begin
                        if (i_len_full) begin
                            o_rewind = 1'b1;
                            o_drop   = 1'b1;
                        end else begin
                            o_push     = 1'b1;
                            o_commit   = 1'b1;
                            o_len_push = 1'b1;
                            o_done     = 1'b1;
                        end
                        state_d = RX_IDLE;
                    end else begin
                        o_push  = 1'b1;
                        state_d = RX_RECV;
                    end
                end
            end
            RX_DROP: begin
                if (i_valid && i_last) state_d = RX_IDLE;
            end
        endcase
    end

    assign o_len = LW'({cnt_q, 2'b00}) + LW'((i_tail == 2'd0) ? 3'd4 : {1'b0, i_tail});

endmodule

// File: rtl/pkt_fifo_mm.sv
module pkt_fifo_mm
    import pf_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int LQ_DEPTH = 4
) (
    input  logic                        i_clk,
    input  logic                        i_rst_n,
    input  logic                        i_bus_sel,
    input  logic                        i_bus_wr,
    input  logic [3:0]                  i_bus_addr,
    input  logic [31:0]                 i_bus_wdata,
    output logic [31:0]                 o_bus_rdata,
    output logic                        o_bus_rvalid,
    output logic                        o_tx_valid,
    output logic [31:0]                 o_tx_data,
    output logic                        o_tx_last,
    output logic [$clog2(DEPTH*4)-1:0]  o_tx_len,
    input  logic                        i_tx_ready,
    input  logic                        i_rx_valid,
    input  logic [31:0]                 i_rx_data,
    input  logic                        i_rx_last,
    input  logic [1:0]                  i_rx_tail,
    output logic                        o_irq
);
    localparam int AW        = $clog2(DEPTH);
    localparam int LW        = $clog2(DEPTH * 4);
    localparam int MIN_BYTES = 16;
    localparam int MAX_BYTES = (DEPTH - 2) * 4;

    reg_ofs_e ofs;
    logic     wr_acc, rd_acc;

    logic [ST_W-1:0] isr_q, ier_q, st_set;
    logic [AW-1:0]   tx_free, tx_staged, tx_ready_cnt, rx_free, rx_staged, rx_occ, rx_left_q;
    logic [31:0]     tx_head, rx_head, rd_val;
    logic            tx_clr, rx_clr, key_ok;
    logic            tx_push_req, tx_push, tx_len_wr, tx_len_ok, tx_commit;
    logic            txq_empty, txq_full, tx_pop_word, tx_pop_len, tx_done;
    logic [LW-1:0]   tx_len_in, txq_head, rxq_head, rx_len_new;
    logic [LW:0]     tx_len_round, rx_len_round;
    logic            rx_push, rx_commit, rx_rewind, rx_len_push, rx_drop, rx_done;
    logic            rxq_empty, rxq_full;
    logic            rx_len_rd, rx_len_ok, rx_data_rd, rx_data_ok;

    assign ofs    = reg_ofs_e'(i_bus_addr);
    assign wr_acc = i_bus_sel && i_bus_wr;
    assign rd_acc = i_bus_sel && !i_bus_wr;
    assign key_ok = (i_bus_wdata == CLR_KEY);

    assign tx_clr = wr_acc && key_ok && (ofs == RG_TX_CLR || ofs == RG_LINK_CLR);
    assign rx_clr = wr_acc && key_ok && (ofs == RG_RX_CLR || ofs == RG_LINK_CLR);

    // ---------------- transmit side ----------------
    assign tx_push_req  = wr_acc && (ofs == RG_TX_DATA);
    assign tx_push      = tx_push_req && (tx_free != '0);
    assign tx_len_wr    = wr_acc && (ofs == RG_TX_LEN);
    assign tx_len_in    = i_bus_wdata[LW-1:0];
    assign tx_len_round = {1'b0, tx_len_in} + (LW+1)'(3);
    assign tx_len_ok    = (tx_len_in >= LW'(MIN_BYTES)) && (tx_len_in <= LW'(MAX_BYTES))
                          && (tx_len_round[LW:2] == {1'b0, tx_staged}) && !txq_full;
    assign tx_commit    = tx_len_wr && tx_len_ok;

    pf_word_ring #(.DEPTH(DEPTH), .W(32)) u_tx_ring (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(tx_clr),
        .i_push(tx_push), .i_push_data(i_bus_wdata),
        .i_commit(tx_commit), .i_rewind(tx_len_wr && !tx_len_ok),
        .i_pop(tx_pop_word), .o_head(tx_head),
        .o_free(tx_free), .o_staged(tx_staged), .o_ready(tx_ready_cnt)
    );

    pf_len_fifo #(.DEPTH(LQ_DEPTH), .W(LW)) u_tx_lenq (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(tx_clr),
        .i_push(tx_commit), .i_din(tx_len_in), .i_pop(tx_pop_len),
        .o_head(txq_head), .o_empty(txq_empty), .o_full(txq_full)
    );

    pf_tx_stream #(.AW(AW), .LW(LW)) u_tx_eng (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(tx_clr),
        .i_len_empty(txq_empty), .i_len_head(txq_head), .i_word(tx_head),
        .i_ready(i_tx_ready), .o_valid(o_tx_valid), .o_data(o_tx_data),
        .o_last(o_tx_last), .o_len(o_tx_len), .o_pop_word(tx_pop_word),
        .o_pop_len(tx_pop_len), .o_done(tx_done)
    );

    // ---------------- receive side ----------------
    assign rx_len_rd    = rd_acc && (ofs == RG_RX_LEN);
    assign rx_len_ok    = !rxq_empty && (rx_left_q == '0);
    assign rx_data_rd   = rd_acc && (ofs == RG_RX_DATA);
    assign rx_data_ok   = (rx_left_q != '0);
    assign rx_len_round = {1'b0, rxq_head} + (LW+1)'(3);

    pf_rx_stream #(.AW(AW), .LW(LW)) u_rx_eng (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(rx_clr),
        .i_valid(i_rx_valid), .i_last(i_rx_last), .i_tail(i_rx_tail),
        .i_free(rx_free), .i_len_full(rxq_full),
        .o_push(rx_push), .o_commit(rx_commit), .o_rewind(rx_rewind),
        .o_len_push(rx_len_push), .o_len(rx_len_new),
        .o_drop(rx_drop), .o_done(rx_done)
    );

    pf_word_ring #(.DEPTH(DEPTH), .W(32)) u_rx_ring (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(rx_clr),
        .i_push(rx_push), .i_push_data(i_rx_data),
        .i_commit(rx_commit), .i_rewind(rx_rewind),
        .i_pop(rx_data_rd && rx_data_ok), .o_head(rx_head),
        .o_free(rx_free), .o_staged(rx_staged), .o_ready(rx_occ)
    );

    pf_len_fifo #(.DEPTH(LQ_DEPTH), .W(LW)) u_rx_lenq (
        .i_clk(i_clk), .i_rst_n(i_rst_n), .i_clr(rx_clr),
        .i_push(rx_len_push), .i_din(rx_len_new), .i_pop(rx_len_rd && rx_len_ok),
        .o_head(rxq_head), .o_empty(rxq_empty), .o_full(rxq_full)
    );

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n)    rx_left_q <= '0;
        else if (rx_clr) rx_left_q <= '0;
        else if (rx_len_rd && rx_len_ok)   rx_left_q <= rx_len_round[AW+1:2];
        else if (rx_data_rd && rx_data_ok) rx_left_q <= rx_left_q - 1'b1;
    end

    // ---------------- status, enable, interrupt ----------------
    always_comb begin
        st_set            = '0;
        st_set[SB_RX_CLR] = rx_clr;
        st_set[SB_TX_CLR] = tx_clr;
        st_set[SB_TX_SZ]  = tx_len_wr && !tx_len_ok && !tx_clr;
        st_set[SB_RX_DN]  = rx_done && !rx_clr;
        st_set[SB_TX_DN]  = tx_done && !tx_clr;
        st_set[SB_TX_OVF] = tx_push_req && (tx_free == '0) && !tx_clr;
        st_set[SB_RX_DRP] = rx_drop && !rx_clr;
        st_set[SB_RX_OVR] = rx_data_rd && !rx_data_ok && (rx_occ != '0);
        st_set[SB_RX_UND] = (rx_len_rd && !rx_len_ok)
                            || (rx_data_rd && !rx_data_ok && (rx_occ == '0));
    end

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            isr_q <= '0;
            ier_q <= '0;
        end else begin
            if (wr_acc && ofs == RG_STATUS)
                isr_q <= (isr_q & ~i_bus_wdata[ST_LSB +: ST_W]) | st_set;
            else
                isr_q <= isr_q | st_set;
            if (wr_acc && ofs == RG_ENABLE) ier_q <= i_bus_wdata[ST_LSB +: ST_W];
        end
    end

    assign o_irq = |(isr_q & ier_q);

    // ---------------- read path ----------------
    always_comb begin
        rd_val = '0;
        case (ofs)
            RG_STATUS:  rd_val[ST_LSB +: ST_W] = isr_q;
            RG_ENABLE:  rd_val[ST_LSB +: ST_W] = ier_q;
            RG_TX_VAC:  rd_val = 32'(tx_free);
            RG_RX_OCC:  rd_val = 32'(rx_occ);
            RG_RX_DATA: rd_val = rx_data_ok ? rx_head : '0;
            RG_RX_LEN:  rd_val = rx_len_ok ? 32'(rxq_head) : '0;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge i_clk or negedge i_rst_n) begin
        if (!i_rst_n) begin
            o_bus_rdata  <= '0;
            o_bus_rvalid <= 1'b0;
        end else begin
            o_bus_rvalid <= rd_acc;
            if (rd_acc) o_bus_rdata <= rd_val;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{tx_ready_cnt, rx_staged};

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int DEPTH = 512
) (
    input logic                     i_clk,
    input logic                     i_rst_n,
    input logic                     i_bus_sel,
    input logic                     i_bus_wr,
    input logic [3:0]               i_bus_addr,
    input logic [31:0]              i_bus_wdata,
    input logic                     o_bus_rvalid,
    input logic                     o_tx_valid,
    input logic [31:0]              o_tx_data,
    input logic                     o_tx_last,
    input logic                     i_tx_ready,
    input logic                     o_irq,
    input logic [8:0]               ier_q,
    input logic [$clog2(DEPTH)-1:0] tx_free
);
    localparam int AW = $clog2(DEPTH);

    a_r1_read_latency: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_bus_sel && !i_bus_wr) |=> o_bus_rvalid);

    a_r3_last_has_valid: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        o_tx_last |-> o_tx_valid);

    a_r3_hold_on_stall: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (o_tx_valid && !i_tx_ready) |=> (o_tx_valid && $stable(o_tx_data) && $stable(o_tx_last)));

    a_r5_full_write_ignored: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_bus_sel && i_bus_wr && i_bus_addr == 4'd4 && tx_free == '0 && !(o_tx_valid && i_tx_ready))
        |=> (tx_free == '0));

    a_r6_tx_clear_empties: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (i_bus_sel && i_bus_wr && i_bus_addr == 4'd2 && i_bus_wdata == 32'h0000_00A5)
        |=> (!o_tx_valid && tx_free == AW'(DEPTH - 1)));

    a_r12_masked_quiet: assert property (@(posedge i_clk) disable iff (!i_rst_n)
        (ier_q == '0) |-> !o_irq);

endmodule

bind pkt_fifo_mm pf_checker #(.DEPTH(DEPTH)) u_chk (
    .i_clk(i_clk), .i_rst_n(i_rst_n), .i_bus_sel(i_bus_sel), .i_bus_wr(i_bus_wr),
    .i_bus_addr(i_bus_addr), .i_bus_wdata(i_bus_wdata), .o_bus_rvalid(o_bus_rvalid),
    .o_tx_valid(o_tx_valid), .o_tx_data(o_tx_data), .o_tx_last(o_tx_last),
    .i_tx_ready(i_tx_ready), .o_irq(o_irq), .ier_q(ier_q), .tx_free(tx_free)
);

// File: tb/pkt_fifo_mm_tb.sv
module pkt_fifo_mm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VAC_MAX    = 511;
    localparam int WATCHDOG   = 100000;

    localparam logic [31:0] B_RX_CLR = 32'h1 << 23;
    localparam logic [31:0] B_TX_CLR = 32'h1 << 24;
    localparam logic [31:0] B_TX_SZ  = 32'h1 << 25;
    localparam logic [31:0] B_RX_DN  = 32'h1 << 26;
    localparam logic [31:0] B_TX_DN  = 32'h1 << 27;
    localparam logic [31:0] B_TX_OVF = 32'h1 << 28;
    localparam logic [31:0] B_RX_DRP = 32'h1 << 29;
    localparam logic [31:0] B_RX_OVR = 32'h1 << 30;
    localparam logic [31:0] B_RX_UND = 32'h1 << 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_valid, tx_last;
    logic [31:0] tx_data;
    logic [10:0] tx_len;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [31:0] rx_data = '0;
    logic [1:0]  rx_tail = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_fifo_mm u_dut (
        .i_clk(clk), .i_rst_n(rst_n), .i_bus_sel(bus_sel), .i_bus_wr(bus_wr),
        .i_bus_addr(bus_addr), .i_bus_wdata(bus_wdata), .o_bus_rdata(bus_rdata),
        .o_bus_rvalid(bus_rvalid), .o_tx_valid(tx_valid), .o_tx_data(tx_data),
        .o_tx_last(tx_last), .o_tx_len(tx_len), .i_tx_ready(tx_ready),
        .i_rx_valid(rx_valid), .i_rx_data(rx_data), .i_rx_last(rx_last),
        .i_rx_tail(rx_tail), .o_irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr_t(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_rd_t(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd_t(a, v);
        chk(tag, v, exp);
    endtask

    task automatic clear_status();
        bus_wr_t(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic tx_fill(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) bus_wr_t(4'd4, base + i);
    endtask

    task automatic tx_expect(input string tag, input int n, input logic [31:0] base, input int len);
        for (int i = 0; i < n; i++) begin
            int guard = 0;
            while (!tx_valid && guard < 50) begin @(negedge clk); guard++; end
            chk({tag, " data"}, tx_data, base + i);
            chk({tag, " last"}, 32'(tx_last), 32'(i == n - 1));
            chk({tag, " len"},  32'(tx_len), 32'(len));
            @(negedge clk);
        end
    endtask

    task automatic rx_send(input int n, input logic [1:0] tail, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_data = base + i; rx_last = (i == n - 1); rx_tail = tail;
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic rx_drain(input string tag, input int n, input logic [31:0] base);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            bus_rd_t(4'd8, v);
            chk(tag, v, base + i);
        end
    endtask

    task automatic t_reset();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R1 rvalid", 32'(bus_rvalid), 32'd1);
        chk("R1 status", bus_rdata, 32'd0);
        expect_reg("R1 enable", 4'd1, 32'd0);
        expect_reg("R1 vacancy", 4'd3, VAC_MAX);
        expect_reg("R1 occupancy", 4'd7, 32'd0);
        chk("R1 tx_valid", 32'(tx_valid), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_tx_basic();
        clear_status();
        tx_fill(4, 32'hA000_0000);
        expect_reg("R2 vacancy after 4", 4'd3, VAC_MAX - 4);
        bus_wr_t(4'd5, 32'd16);
        tx_expect("R3 basic", 4, 32'hA000_0000, 16);
        expect_reg("R3 tx done flag", 4'd0, B_TX_DN);
        expect_reg("R2 vacancy restored", 4'd3, VAC_MAX);
    endtask

    task automatic t_tx_stall();
        clear_status();
        tx_ready = 1'b0;
        tx_fill(10, 32'hB000_0000);
        bus_wr_t(4'd5, 32'd37);
        repeat (3) @(negedge clk);
        chk("R3 stall valid", 32'(tx_valid), 32'd1);
        chk("R3 stall data", tx_data, 32'hB000_0000);
        @(negedge clk);
        chk("R3 stall hold", tx_data, 32'hB000_0000);
        tx_ready = 1'b1;
        tx_expect("R3 odd length", 10, 32'hB000_0000, 37);
        expect_reg("R3 odd done flag", 4'd0, B_TX_DN);
    endtask

    task automatic t_tx_size();
        int seen = 0;
        clear_status();
        tx_fill(3, 32'hC000_0000);
        bus_wr_t(4'd5, 32'd12);
        for (int i = 0; i < 6; i++) begin seen += int'(tx_valid); @(negedge clk); end
        chk("R4 short dropped no output", seen, 0);
        expect_reg("R4 short flag", 4'd0, B_TX_SZ);
        expect_reg("R4 short vacancy", 4'd3, VAC_MAX);
        clear_status();
        tx_fill(5, 32'hC100_0000);
        bus_wr_t(4'd5, 32'd16);
        expect_reg("R4 mismatch flag", 4'd0, B_TX_SZ);
        expect_reg("R4 mismatch vacancy", 4'd3, VAC_MAX);
        clear_status();
        bus_wr_t(4'd5, 32'd0);
        expect_reg("R4 zero flag", 4'd0, B_TX_SZ);
        chk("R4 no stream", 32'(tx_valid), 32'd0);
    endtask

    task automatic t_tx_overrun();
        clear_status();
        tx_fill(VAC_MAX, 32'hD000_0000);
        expect_reg("R5 full vacancy", 4'd3, 32'd0);
        bus_wr_t(4'd4, 32'hDEAD_BEEF);
        expect_reg("R5 overrun flag", 4'd0, B_TX_OVF);
        expect_reg("R5 still full", 4'd3, 32'd0);
        bus_wr_t(4'd2, 32'h0000_00A5);
        expect_reg("R6 tx clear vacancy", 4'd3, VAC_MAX);
    endtask

    task automatic t_keyed();
        clear_status();
        tx_fill(2, 32'hE000_0000);
        bus_wr_t(4'd2, 32'h0000_005A);
        expect_reg("R6 wrong key vacancy", 4'd3, VAC_MAX - 2);
        expect_reg("R6 wrong key status", 4'd0, 32'd0);
        bus_wr_t(4'd2, 32'h0000_00A5);
        expect_reg("R6 tx key vacancy", 4'd3, VAC_MAX);
        expect_reg("R6 tx key flag", 4'd0, B_TX_CLR);
        clear_status();
        rx_send(2, 2'd0, 32'hE100_0000);
        bus_wr_t(4'd6, 32'h0000_01A5);
        expect_reg("R6 rx wrong key occ", 4'd7, 32'd2);
        bus_wr_t(4'd6, 32'h0000_00A5);
        expect_reg("R6 rx key occ", 4'd7, 32'd0);
        expect_reg("R6 rx key flag", 4'd0, B_RX_CLR | B_RX_DN);
        clear_status();
        tx_fill(1, 32'hE200_0000);
        bus_wr_t(4'd10, 32'h0000_00A5);
        expect_reg("R6 stream clear flags", 4'd0, B_TX_CLR | B_RX_CLR);
        expect_reg("R6 stream clear vac", 4'd3, VAC_MAX);
    endtask

    task automatic t_rx_basic();
        clear_status();
        rx_send(5, 2'd2, 32'h5000_0000);
        expect_reg("R7 occupancy", 4'd7, 32'd5);
        expect_reg("R7 done flag", 4'd0, B_RX_DN);
        expect_reg("R7 length tail2", 4'd9, 32'd18);
        rx_drain("R7 data", 5, 32'h5000_0000);
        expect_reg("R7 drained", 4'd7, 32'd0);
        rx_send(3, 2'd0, 32'h5100_0000);
        expect_reg("R7 length tail4", 4'd9, 32'd12);
        rx_drain("R7 data b", 3, 32'h5100_0000);
    endtask

    task automatic t_rx_errs();
        clear_status();
        expect_reg("R8 empty length", 4'd9, 32'd0);
        expect_reg("R8 empty flag", 4'd0, B_RX_UND);
        clear_status();
        expect_reg("R9 empty data", 4'd8, 32'd0);
        expect_reg("R9 empty flag", 4'd0, B_RX_UND);
        rx_send(2, 2'd0, 32'h6000_0000);
        clear_status();
        expect_reg("R9 unopened data", 4'd8, 32'd0);
        expect_reg("R9 unopened flag", 4'd0, B_RX_OVR);
        expect_reg("R9 occ kept", 4'd7, 32'd2);
        clear_status();
        expect_reg("R8 length", 4'd9, 32'd8);
        expect_reg("R8 early reread", 4'd9, 32'd0);
        expect_reg("R8 reread flag", 4'd0, B_RX_UND);
        rx_drain("R8 data after", 2, 32'h6000_0000);
    endtask

    task automatic t_rx_drop();
        clear_status();
        rx_send(VAC_MAX, 2'd0, 32'h7000_0000);
        expect_reg("R10 full occ", 4'd7, VAC_MAX);
        clear_status();
        rx_send(2, 2'd0, 32'h7100_0000);
        expect_reg("R10 drop flag", 4'd0, B_RX_DRP);
        expect_reg("R10 occ kept", 4'd7, VAC_MAX);
        expect_reg("R7 max length", 4'd9, 32'd2044);
        bus_wr_t(4'd6, 32'h0000_00A5);
    endtask

    task automatic t_w1c();
        clear_status();
        bus_wr_t(4'd5, 32'd0);
        rx_send(1, 2'd1, 32'h8000_0000);
        expect_reg("R11 both set", 4'd0, B_TX_SZ | B_RX_DN);
        bus_wr_t(4'd0, B_TX_SZ);
        expect_reg("R11 one cleared", 4'd0, B_RX_DN);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = B_RX_UND;
        rx_valid = 1'b1; rx_data = 32'h8100_0000; rx_last = 1'b1; rx_tail = 2'd0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0; rx_last = 1'b0;
        expect_reg("R11 unwritten bit kept", 4'd0, B_RX_DN);
        bus_wr_t(4'd6, 32'h0000_00A5);
    endtask

    task automatic t_irq();
        bus_wr_t(4'd1, B_RX_DN);
        clear_status();
        chk("R12 quiet", 32'(irq), 32'd0);
        bus_wr_t(4'd5, 32'd0);
        chk("R12 masked bit", 32'(irq), 32'd0);
        rx_send(1, 2'd0, 32'h9000_0000);
        chk("R12 enabled bit", 32'(irq), 32'd1);
        bus_wr_t(4'd0, B_RX_DN);
        chk("R12 after clear", 32'(irq), 32'd0);
        bus_wr_t(4'd1, 32'd0);
        bus_wr_t(4'd6, 32'h0000_00A5);
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_stall();
        t_tx_size();
        t_tx_overrun();
        t_keyed();
        t_rx_basic();
        t_rx_errs();
        t_rx_drop();
        t_w1c();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule